// File: doc/BRIEF.md
# Bit-Serial Dual-Bank Register Store

This block holds the working registers of a small bit-serial computer. Eight 32-bit registers live as eight tracks: bit `t` of every memory word belongs to track `t`, and the memory address is the bit position. Track 0 is meant for the accumulator, track 1 for the operand and track 2 for the program counter. The other five tracks are free for more registers or for timing patterns.

A single position counter steps through bit positions 0 to 31 and addresses two 32x8 memories together. During one word time, one memory supplies the bits and the other receives them. The two memories swap these roles each time the counter wraps. Each bit that is read is written to the other memory at the same address. The only exception is a track whose replace strobe is high in that cycle; that track's new bit is written instead. A replacement therefore becomes visible one word time later, at the same bit position. Bit position 0 is the least significant bit, so serial adders downstream see carries in counter order.

The control logic reads the current bit of all tracks from `trk_bits`. It uses `bit_pos`, `word_start` and `word_end` to line up its serial operations, and `rd_bank` to see which memory is being read.

Top module: `serial_regstore`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the store clears both memories, sets the position counter to 0 and selects bank 0 for reading. The replace inputs are ignored during this time. After reset, `trk_bits` reads 0 on every track.
- R2: Outside reset, `bit_pos` goes up by one at each clock edge and wraps from 31 to 0.
- R3: `word_start` is high exactly when `bit_pos` is 0. `word_end` is high exactly when `bit_pos` is 31. The two are never high together.
- R4: `rd_bank` changes value at the edge where `bit_pos` wraps from 31 to 0, and only at that edge.
- R5: A track whose `repl_en` bit stays low for a whole word shows the same bit values, at the same positions, in the following word.
- R6: When `repl_en[t]` is high at position p, `trk_bits[t]` shows `repl_bits[t]` at position p of the next word. The current word's output for that track is not affected. Bit p of a register value is the bit at position p, so loading value V at positions 0..31 reads V back in the next word.
- R7: Replacement is independent per track. In any cycle, tracks whose `repl_en` bit is low recirculate, whatever the other tracks do.
- R8: A reset applied in the middle of a word, with replace strobes active, still clears every track and restarts at position 0 with bank 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| repl_en | input | 8 | Per-track replace strobe for the current bit time |
| repl_bits | input | 8 | Replacement bit for each track |
| trk_bits | output | 8 | Current bit of every track at `bit_pos` |
| bit_pos | output | 5 | Current bit position, 0 is LSB |
| word_start | output | 1 | High while `bit_pos` is 0 |
| word_end | output | 1 | High while `bit_pos` is 31 |
| rd_bank | output | 1 | Index of the memory currently being read |

## Verification
A counter or bank-select fault shows up at once: `bit_pos`, the boundary flags or `rd_bank` go wrong in the very next cycle. A wrong write address, a write to the wrong bank or a broken recirculation path stays hidden for a while. It appears on `trk_bits` exactly one word time, 32 cycles, after the bad write, at the position that was damaged. For that reason the bench compares every track at every bit time against a word-by-word model across many words. It checks both tracks that were replaced and tracks that were left untouched.

// File: rtl/regstore_pkg.sv
// Package: regstore_pkg
// Shared constants for the bit-serial register store: default geometry and
// the conventional role of the low tracks. Assumes nothing beyond 1800-2017.
package regstore_pkg;

    localparam int RS_TRACKS    = 8;
    localparam int RS_WORD_BITS = 32;
    localparam int RS_BANKS     = 2;

    // Conventional track roles; remaining tracks are free for the caller.
    localparam int TRK_ACC = 0;
    localparam int TRK_OPR = 1;
    localparam int TRK_PC  = 2;

endpackage

// File: rtl/rs_bit_counter.sv
// Module: rs_bit_counter
// Steps the bit position of the serial word and flips the read-bank select
// when the position wraps. Assumes WORD_BITS >= 2. Reset is synchronous and
// active low; it zeroes the position and selects bank 0.
module rs_bit_counter #(
    parameter int WORD_BITS = 32,
    localparam int CNT_W    = $clog2(WORD_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] pos,
    output logic             at_first,
    output logic             at_last,
    output logic             bank
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

    // Advance the bit position, wrapping at the last bit of the word.
    always_ff @(posedge clk) begin
        if (!rst_n)          pos <= '0;
        else if (at_last)    pos <= '0;
        else                 pos <= pos + 1'b1;
    end

    // Swap the read and write memories at each word boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)          bank <= 1'b0;
        else if (at_last)    bank <= ~bank;
    end

    // Decode the word boundary flags.
    always_comb begin
        at_first = (pos == '0);
        at_last  = (pos == LAST);
    end

    // R2
    pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pos == (($past(pos) == LAST) ? '0 : $past(pos) + 1'b1));

    // R4
    bank_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pos) == LAST) |-> bank != $past(bank));

    // R4
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pos) != LAST) |-> $stable(bank));

    // R3
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(at_first && at_last));

endmodule

// File: rtl/rs_track_mem.sv
// Module: rs_track_mem
// One WORD_BITS x TRACKS memory. Each data bit is a track and the address
// is the bit position. The read is combinational; the write commits on the
// clock edge. A synchronous active-low reset clears every location and takes
// priority over a write.
module rs_track_mem #(
    parameter int TRACKS    = 8,
    parameter int WORD_BITS = 32,
    localparam int CNT_W    = $clog2(WORD_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  addr,
    input  logic              we,
    input  logic [TRACKS-1:0] wdata,
    output logic [TRACKS-1:0] rdata
);

    logic [TRACKS-1:0] cells [WORD_BITS];

    // Clear all cells on reset, otherwise store the write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORD_BITS; i++) cells[i] <= '0;
        end else if (we) begin
            cells[addr] <= wdata;
        end
    end

    // Present the addressed location without waiting for a clock.
    always_comb rdata = cells[addr];

endmodule

// File: rtl/rs_track_merge.sv
// Module: rs_track_merge
// Chooses the bit to write back for each track: the bit just read, or the
// replacement bit when that track's strobe is high. Purely combinational;
// it assumes the caller aligns all three vectors to the same bit position.
module rs_track_merge #(
    parameter int TRACKS = 8
) (
    input  logic [TRACKS-1:0] cur_bits,
    input  logic [TRACKS-1:0] repl_en,
    input  logic [TRACKS-1:0] repl_bits,
    output logic [TRACKS-1:0] next_bits
);

    for (genvar t = 0; t < TRACKS; t++) begin : g_trk
        // Per-track recirculate-or-replace select.
        always_comb next_bits[t] = repl_en[t] ? repl_bits[t] : cur_bits[t];
    end

endmodule

// File: rtl/serial_regstore.sv
// Module: serial_regstore
// Bit-serial register store built from two track memories that swap roles
// every word. The read bank feeds trk_bits; the merged bit stream is written
// to the other bank at the same address. Assumes the control logic drives
// repl_en/repl_bits for the bit position shown in the same cycle.
module serial_regstore
    import regstore_pkg::*;
#(
    parameter int TRACKS    = RS_TRACKS,
    parameter int WORD_BITS = RS_WORD_BITS,
    localparam int CNT_W    = $clog2(WORD_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TRACKS-1:0] repl_en,
    input  logic [TRACKS-1:0] repl_bits,
    output logic [TRACKS-1:0] trk_bits,
    output logic [CNT_W-1:0]  bit_pos,
    output logic              word_start,
    output logic              word_end,
    output logic              rd_bank
);

    logic [TRACKS-1:0] bank_rdata [RS_BANKS];
    logic [TRACKS-1:0] wr_bits;

    rs_bit_counter #(.WORD_BITS(WORD_BITS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .pos      (bit_pos),
        .at_first (word_start),
        .at_last  (word_end),
        .bank     (rd_bank)
    );

    for (genvar b = 0; b < RS_BANKS; b++) begin : g_bank
        logic bank_we;
        // Only the bank not being read takes the write.
        always_comb bank_we = (rd_bank != 1'(b));

        rs_track_mem #(.TRACKS(TRACKS), .WORD_BITS(WORD_BITS)) u_mem (
            .clk   (clk),
            .rst_n (rst_n),
            .addr  (bit_pos),
            .we    (bank_we),
            .wdata (wr_bits),
            .rdata (bank_rdata[b])
        );
    end

    // Route the read bank to the serial outputs.
    always_comb trk_bits = bank_rdata[rd_bank];

    rs_track_merge #(.TRACKS(TRACKS)) u_merge (
        .cur_bits  (trk_bits),
        .repl_en   (repl_en),
        .repl_bits (repl_bits),
        .next_bits (wr_bits)
    );

    // R1 R8
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (trk_bits == '0 && bit_pos == '0 && !rd_bank));

    // R3
    start_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_start == (bit_pos == '0));

endmodule

// File: tb/serial_regstore_tb.sv
module serial_regstore_tb_top;

    localparam int NT = 8;
    localparam int WB = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT-1:0] repl_en = '0;
    logic [NT-1:0] repl_bits = '0;
    logic [NT-1:0] trk_bits;
    logic [4:0]    bit_pos;
    logic          word_start, word_end, rd_bank;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // model state
    int          m_pos = 0;
    bit          m_bank = 0;
    logic [WB-1:0] cur_w [NT];
    logic [WB-1:0] nxt_w [NT];
    bit          touched_cur [NT];
    bit          touched_nxt [NT];

    serial_regstore dut_i (
        .clk(clk), .rst_n(rst_n), .repl_en(repl_en), .repl_bits(repl_bits),
        .trk_bits(trk_bits), .bit_pos(bit_pos), .word_start(word_start),
        .word_end(word_end), .rd_bank(rd_bank)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_bit(input int t);
        return cur_w[t][m_pos];
    endfunction

    task automatic model_clear();
        m_pos = 0; m_bank = 0;
        for (int t = 0; t < NT; t++) begin
            cur_w[t] = '0; nxt_w[t] = '0;
            touched_cur[t] = 0; touched_nxt[t] = 0;
        end
    endtask

    // At a negedge: check outputs, drive inputs, advance one clock.
    task automatic step(input logic [NT-1:0] en, input logic [NT-1:0] nb);
        chk(bit_pos == 5'(m_pos), "R2 bit_pos", bit_pos, m_pos);
        chk(word_start == (m_pos == 0) && word_end == (m_pos == WB-1),
            "R3 flags", {word_start, word_end}, {m_pos == 0, m_pos == WB-1});
        chk(rd_bank == m_bank, "R4 rd_bank", rd_bank, m_bank);
        for (int t = 0; t < NT; t++) begin
            if (touched_cur[t])
                chk(trk_bits[t] == exp_bit(t), "R6 replaced track", trk_bits[t], exp_bit(t));
            else
                chk(trk_bits[t] == exp_bit(t), "R5 R7 recirculated track", trk_bits[t], exp_bit(t));
        end
        repl_en = en;
        repl_bits = nb;
        for (int t = 0; t < NT; t++) begin
            if (en[t]) begin
                nxt_w[t][m_pos] = nb[t];
                touched_nxt[t] = 1;
            end else begin
                nxt_w[t][m_pos] = cur_w[t][m_pos];
            end
        end
        @(posedge clk);
        if (m_pos == WB-1) begin
            m_pos = 0; m_bank = ~m_bank;
            for (int t = 0; t < NT; t++) begin
                cur_w[t] = nxt_w[t];
                touched_cur[t] = touched_nxt[t];
                touched_nxt[t] = 0;
            end
        end else begin
            m_pos++;
        end
        @(negedge clk);
    endtask

    // Reset with live strobes; check cleared state while still in reset.
    task automatic do_reset(input string req);
        rst_n = 1'b0;
        repl_en = NT'($urandom);
        repl_bits = NT'($urandom);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(trk_bits == '0, {req, " tracks cleared"}, trk_bits, 0);
        chk(bit_pos == '0 && word_start, {req, " position"}, bit_pos, 0);
        chk(rd_bank == 1'b0, {req, " bank"}, rd_bank, 0);
        model_clear();
        repl_en = '0;
        repl_bits = '0;
        rst_n = 1'b1;
    endtask

    task automatic run_to_start();
        while (m_pos != 0) step('0, '0);
    endtask

    // Load a value into one track over a full word, LSB first.
    task automatic load_word(input int t, input logic [WB-1:0] v);
        run_to_start();
        for (int p = 0; p < WB; p++) step(NT'(1) << t, NT'(v[p]) << t);
    endtask

    task automatic read_word(input int t, output logic [WB-1:0] v);
        run_to_start();
        v = '0;
        for (int p = 0; p < WB; p++) begin
            v[p] = trk_bits[t];
            step('0, '0);
        end
    endtask

    initial begin
        logic [WB-1:0] got;
        void'($urandom(32'd20240611));
        model_clear();
        @(negedge clk);
        // R1: reset with replace strobes driven
        do_reset("R1");

        // R6: directed loads, including boundary positions 0 and 31
        load_word(0, 32'hDEAD_BEEF);
        load_word(2, 32'h8000_0001);
        read_word(0, got);
        chk(got == 32'hDEAD_BEEF, "R6 acc readback", got, 32'hDEAD_BEEF);
        read_word(2, got);
        chk(got == 32'h8000_0001, "R6 pc readback", got, 32'h8000_0001);
        read_word(0, got);
        chk(got == 32'hDEAD_BEEF, "R5 acc held", got, 32'hDEAD_BEEF);

        // R7: random sparse per-track replacement
        for (int w = 0; w < 30; w++)
            for (int p = 0; p < WB; p++)
                step(NT'($urandom & $urandom), NT'($urandom));

        // R5: several quiet words
        for (int i = 0; i < 3 * WB; i++) step('0, '0);

        // R8: reset in the middle of a word
        for (int i = 0; i < 13; i++) step(NT'($urandom), NT'($urandom));
        do_reset("R8");
        for (int i = 0; i < 2 * WB; i++) step('0, '0);

        // R7: all tracks replaced, then some
        for (int p = 0; p < WB; p++) step('1, NT'($urandom));
        for (int w = 0; w < 4; w++)
            for (int p = 0; p < WB; p++)
                step(NT'($urandom) & 8'hA5, NT'($urandom));
        for (int i = 0; i < 2 * WB; i++) step('0, '0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule